// File: doc/BRIEF.md
# Control Bus Tree Switch

This block is one node of a tree-shaped control network. Each link is 16 bits wide and runs in both directions at the same time. All links share one 125 MHz clock. Every link frames its packets with a start marker, an end marker and a valid/ready handshake. A word moves only in a cycle where the sender's valid and the receiver's ready are both high. The node has one port facing the root and `N_DOWN` ports facing endpoints or lower switches. At most sixteen endpoints are supported.

Traffic from the root is copied to every downstream port. The copy moves in lock-step: the ready returned to the root is the AND of all downstream readies. A word is offered to a port only when every other port can also take it.

Traffic from the endpoints is merged onto the single upstream port. A round-robin arbiter grants one port at a time and keeps that grant until the packet's end word has passed. Packets therefore never interleave. No path exists from one downstream port to another. Every direction passes through a two-entry register stage, so a word needs one cycle per stage and a link can carry one word per cycle.

Top module: `cbsw_top`

## Requirements
- R1: After reset, every valid output (`dn_out_src_rdy`, `up_out_src_rdy`) is low and every ready output (`up_in_dst_rdy`, `dn_in_dst_rdy`) is high.
- R2: Every word accepted on the upstream input appears exactly once, in order, on every downstream output. Data, start bit and end bit are unchanged.
- R3: A copied word transfers on all downstream ports in the same cycle. No port sees a transfer while any other downstream ready is low.
- R4: No word is lost or duplicated under backpressure on any output. While a valid output is held without ready, its data and framing bits stay stable.
- R5: Once a packet's start word from a downstream port has transferred upstream, no word from another port goes upstream until that packet's end word has transferred.
- R6: Arbitration is round robin. After a packet from port i ends, the search starts at port i+1, wrapping to 0. Right after reset the search starts at port 0. With all ports requesting, the packet order is 0, 1, 2, 3.
- R7: A single-word packet (start and end bits both set) takes no lock. It advances the round-robin pointer like any other packet.
- R8: Words entering on downstream inputs never appear on any downstream output. A downstream output is valid only while a word from upstream is pending.
- R9: With all readies held high, a packet of L words from upstream leaves on the downstream ports in L consecutive cycles. The upstream input is never stalled while this happens.
- R10: The first word of an upstream-bound packet carries its endpoint identifier in bits [3:0]. It passes through unchanged, so the receiver can attribute each packet to its source port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_in_data | input | DW | Word arriving from the root side |
| up_in_sop | input | 1 | Start of packet, root side in |
| up_in_eop | input | 1 | End of packet, root side in |
| up_in_src_rdy | input | 1 | Valid, root side in |
| up_in_dst_rdy | output | 1 | Ready back to the root side |
| dn_out_data | output | N_DOWN*DW | Copied word, one slice per downstream port |
| dn_out_sop | output | N_DOWN | Start of packet per downstream port |
| dn_out_eop | output | N_DOWN | End of packet per downstream port |
| dn_out_src_rdy | output | N_DOWN | Valid per downstream port |
| dn_out_dst_rdy | input | N_DOWN | Ready from each downstream port |
| dn_in_data | input | N_DOWN*DW | Word from each downstream port |
| dn_in_sop | input | N_DOWN | Start of packet per downstream input |
| dn_in_eop | input | N_DOWN | End of packet per downstream input |
| dn_in_src_rdy | input | N_DOWN | Valid per downstream input |
| dn_in_dst_rdy | output | N_DOWN | Ready back to each downstream port |
| up_out_data | output | DW | Merged word toward the root |
| up_out_sop | output | 1 | Start of packet toward the root |
| up_out_eop | output | 1 | End of packet toward the root |
| up_out_src_rdy | output | 1 | Valid toward the root |
| up_out_dst_rdy | input | 1 | Ready from the root side |

## Verification
The hardest case to reach is a fight between ports while the upstream sink stalls at random. In that case, a locked grant must outlast stalls in the middle of the packet. A waiting port's packet must also sit in its input stage without leaking into the stream.

The stimulus gets there in two ways. First, it starts all four downstream drivers in the same cycle, each sending a packet, so every request is present at once and the round-robin order shows directly. Second, it runs long mixed-length streams, including single-word packets, from all ports together while the upstream ready toggles randomly. Every middle word encodes its source, so any interleave fails the scoreboard. For the copy path, each downstream ready toggles on its own, which forces the all-or-none rule to hold back ports that are ready.

// File: rtl/cbsw_pkg.sv
package cbsw_pkg;

  localparam int ID_W     = 4;
  localparam int MAX_PORT = 16;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] idx;
  } pick_t;

  // Ready of every port except 'me'; unused high bits are expected at 1.
  function automatic logic others_ready(input logic [MAX_PORT-1:0] rdy, input int me);
    logic [MAX_PORT-1:0] mask;
    mask = rdy;
    mask[me[ID_W-1:0]] = 1'b1;
    return &mask;
  endfunction

  // Next index after i within 0..n-1.
  function automatic logic [ID_W-1:0] wrap_inc(input logic [ID_W-1:0] i, input int n);
    int nxt;
    nxt = int'(i) + 1;
    if (nxt >= n) nxt = 0;
    return ID_W'(nxt);
  endfunction

  // First requesting index found searching upward from ptr, wrapping at n.
  function automatic pick_t rr_pick(input logic [MAX_PORT-1:0] req,
                                    input logic [ID_W-1:0] ptr, input int n);
    pick_t r;
    int    c;
    r = '0;
    for (int k = MAX_PORT - 1; k >= 0; k--) begin
      if (k < n) begin
        c = int'(ptr) + k;
        if (c >= n) c = c - n;
        if (req[c[ID_W-1:0]]) begin
          r.found = 1'b1;
          r.idx   = ID_W'(c);
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cbsw_skid.sv
module cbsw_skid #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  input  logic         out_ready
);

  logic         main_v, spare_v;
  logic [W-1:0] main_w, spare_w;

  assign in_ready  = !spare_v;
  assign out_valid = main_v;
  assign out_word  = main_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_v  <= 1'b0;
      spare_v <= 1'b0;
      main_w  <= '0;
      spare_w <= '0;
    end else if (out_ready || !main_v) begin
      if (spare_v) begin
        main_v  <= 1'b1;
        main_w  <= spare_w;
        spare_v <= 1'b0;
      end else begin
        main_v  <= in_valid;
        main_w  <= in_word;
      end
    end else if (in_valid && !spare_v) begin
      spare_v <= 1'b1;
      spare_w <= in_word;
    end
  end

endmodule

// File: rtl/cbsw_fork.sv
module cbsw_fork
  import cbsw_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 18
) (
  input  logic           in_valid,
  input  logic [W-1:0]   in_word,
  output logic           in_ready,
  output logic [N-1:0]   out_valid,
  output logic [N*W-1:0] out_word,
  input  logic [N-1:0]   out_ready
);

  logic [MAX_PORT-1:0] rdy_ext;

  always_comb begin
    rdy_ext        = '1;
    rdy_ext[N-1:0] = out_ready;
  end

  assign in_ready = &out_ready;

  for (genvar i = 0; i < N; i++) begin : g_port
    assign out_valid[i]         = in_valid && others_ready(rdy_ext, i);
    assign out_word[i*W +: W]   = in_word;
  end

endmodule

// File: rtl/cbsw_rr_arb.sv
module cbsw_rr_arb
  import cbsw_pkg::*;
#(
  parameter int N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic            take,
  input  logic            last,
  output logic [N-1:0]    grant,
  output logic            locked,
  output logic [ID_W-1:0] sel
);

  logic [ID_W-1:0] ptr_q, owner_q;
  logic            lock_q;
  pick_t           pick;

  assign pick   = rr_pick(MAX_PORT'(req), ptr_q, N);
  assign locked = lock_q;
  assign sel    = lock_q ? owner_q : pick.idx;
  assign grant  = (lock_q || pick.found) ? (N'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      owner_q <= '0;
      lock_q  <= 1'b0;
    end else if (take) begin
      if (last) begin
        lock_q <= 1'b0;
        ptr_q  <= wrap_inc(sel, N);
      end else begin
        lock_q  <= 1'b1;
        owner_q <= sel;
      end
    end
  end

endmodule

// File: rtl/cbsw_merge.sv
module cbsw_merge
  import cbsw_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_valid,
  input  logic [N*W-1:0] in_word,
  output logic [N-1:0]   in_ready,
  output logic           out_valid,
  output logic [W-1:0]   out_word,
  input  logic           out_ready,
  output logic [N-1:0]   grant,
  output logic           locked,
  output logic           take,
  output logic           last
);

  logic [ID_W-1:0] sel;

  cbsw_rr_arb #(.N(N)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (in_valid),
    .take   (take),
    .last   (last),
    .grant  (grant),
    .locked (locked),
    .sel    (sel)
  );

  always_comb begin
    out_word = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) out_word = out_word | in_word[i*W +: W];
    end
  end

  assign out_valid = |(in_valid & grant);
  assign in_ready  = grant & {N{out_ready}};
  assign take      = out_valid && out_ready;
  assign last      = out_word[W-2];

endmodule

// File: rtl/cbsw_top.sv
module cbsw_top #(
  parameter int N_DOWN = 4,
  parameter int DW     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        up_in_data,
  input  logic                 up_in_sop,
  input  logic                 up_in_eop,
  input  logic                 up_in_src_rdy,
  output logic                 up_in_dst_rdy,
  output logic [N_DOWN*DW-1:0] dn_out_data,
  output logic [N_DOWN-1:0]    dn_out_sop,
  output logic [N_DOWN-1:0]    dn_out_eop,
  output logic [N_DOWN-1:0]    dn_out_src_rdy,
  input  logic [N_DOWN-1:0]    dn_out_dst_rdy,
  input  logic [N_DOWN*DW-1:0] dn_in_data,
  input  logic [N_DOWN-1:0]    dn_in_sop,
  input  logic [N_DOWN-1:0]    dn_in_eop,
  input  logic [N_DOWN-1:0]    dn_in_src_rdy,
  output logic [N_DOWN-1:0]    dn_in_dst_rdy,
  output logic [DW-1:0]        up_out_data,
  output logic                 up_out_sop,
  output logic                 up_out_eop,
  output logic                 up_out_src_rdy,
  input  logic                 up_out_dst_rdy
);

  // Word layout inside the switch: {sop, eop, data}.
  localparam int W = DW + 2;

  // Root-to-endpoint copy path.
  logic             bc_valid, bc_ready;
  logic [W-1:0]     bc_word;
  logic [N_DOWN*W-1:0] fan_word;

  cbsw_skid #(.W(W)) u_down_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (up_in_src_rdy),
    .in_word   ({up_in_sop, up_in_eop, up_in_data}),
    .in_ready  (up_in_dst_rdy),
    .out_valid (bc_valid),
    .out_word  (bc_word),
    .out_ready (bc_ready)
  );

  cbsw_fork #(.N(N_DOWN), .W(W)) u_fork (
    .in_valid  (bc_valid),
    .in_word   (bc_word),
    .in_ready  (bc_ready),
    .out_valid (dn_out_src_rdy),
    .out_word  (fan_word),
    .out_ready (dn_out_dst_rdy)
  );

  for (genvar i = 0; i < N_DOWN; i++) begin : g_fan
    assign dn_out_sop[i]             = fan_word[i*W + W - 1];
    assign dn_out_eop[i]             = fan_word[i*W + W - 2];
    assign dn_out_data[i*DW +: DW]   = fan_word[i*W +: DW];
  end

  // Endpoint-to-root merge path.
  logic [N_DOWN-1:0]   ep_valid, ep_ready;
  logic [N_DOWN*W-1:0] ep_word;
  logic                mg_valid, mg_ready;
  logic [W-1:0]        mg_word;
  logic [W-1:0]        top_word;

  // Named internal events for the checker.
  logic [N_DOWN-1:0]   arb_grant;
  logic                arb_locked;
  logic                arb_take;
  logic                arb_last;

  for (genvar i = 0; i < N_DOWN; i++) begin : g_ingress
    cbsw_skid #(.W(W)) u_in_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dn_in_src_rdy[i]),
      .in_word   ({dn_in_sop[i], dn_in_eop[i], dn_in_data[i*DW +: DW]}),
      .in_ready  (dn_in_dst_rdy[i]),
      .out_valid (ep_valid[i]),
      .out_word  (ep_word[i*W +: W]),
      .out_ready (ep_ready[i])
    );
  end

  cbsw_merge #(.N(N_DOWN), .W(W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ep_valid),
    .in_word   (ep_word),
    .in_ready  (ep_ready),
    .out_valid (mg_valid),
    .out_word  (mg_word),
    .out_ready (mg_ready),
    .grant     (arb_grant),
    .locked    (arb_locked),
    .take      (arb_take),
    .last      (arb_last)
  );

  cbsw_skid #(.W(W)) u_up_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mg_valid),
    .in_word   (mg_word),
    .in_ready  (mg_ready),
    .out_valid (up_out_src_rdy),
    .out_word  (top_word),
    .out_ready (up_out_dst_rdy)
  );

  assign up_out_sop  = top_word[W-1];
  assign up_out_eop  = top_word[W-2];
  assign up_out_data = top_word[DW-1:0];

endmodule

// File: rtl/cbsw_top_chk.sv
module cbsw_top_chk #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_in_src_rdy,
  input logic          up_in_dst_rdy,
  input logic [N-1:0]  dn_out_src_rdy,
  input logic [N-1:0]  dn_out_dst_rdy,
  input logic [DW-1:0] up_out_data,
  input logic          up_out_sop,
  input logic          up_out_eop,
  input logic          up_out_src_rdy,
  input logic          up_out_dst_rdy,
  input logic [N-1:0]  arb_grant,
  input logic          arb_locked,
  input logic          arb_take,
  input logic          arb_last
);

  logic [N-1:0] dn_fire;
  logic         up_in_fire, up_out_fire;
  logic [2:0]   pending;
  logic         pkt_open;

  assign dn_fire     = dn_out_src_rdy & dn_out_dst_rdy;
  assign up_in_fire  = up_in_src_rdy && up_in_dst_rdy;
  assign up_out_fire = up_out_src_rdy && up_out_dst_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      pkt_open <= 1'b0;
    end else begin
      pending <= pending + 3'(up_in_fire) - 3'(|dn_fire);
      if (up_out_fire) begin
        if (up_out_eop)      pkt_open <= 1'b0;
        else if (up_out_sop) pkt_open <= 1'b1;
      end
    end
  end

  // R3: copies move on all ports together or not at all
  a_r3_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_fire == '0) || (&dn_fire));

  // R4: held upstream word stays put until taken
  a_r4_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_out_src_rdy && !up_out_dst_rdy) |=>
      (up_out_src_rdy && $stable(up_out_data) && $stable(up_out_sop) && $stable(up_out_eop)));

  // R5: a start word never arrives inside an open packet
  a_r5_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    (up_out_fire && up_out_sop) |-> !pkt_open);

  // R5: a continuation word only arrives inside an open packet
  a_r5_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    (up_out_fire && !up_out_sop) |-> pkt_open);

  // R5: a held grant does not move before the end word is taken
  a_r5_grant_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_locked && !(arb_take && arb_last)) |=> $stable(arb_grant));

  // R6: at most one port granted
  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_grant));

  // R8: downstream outputs only carry words that came from upstream
  a_r8_no_lateral: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_out_src_rdy) |-> (pending != 3'd0));

endmodule

bind cbsw_top cbsw_top_chk #(.N(N_DOWN), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .up_in_src_rdy  (up_in_src_rdy),
  .up_in_dst_rdy  (up_in_dst_rdy),
  .dn_out_src_rdy (dn_out_src_rdy),
  .dn_out_dst_rdy (dn_out_dst_rdy),
  .up_out_data    (up_out_data),
  .up_out_sop     (up_out_sop),
  .up_out_eop     (up_out_eop),
  .up_out_src_rdy (up_out_src_rdy),
  .up_out_dst_rdy (up_out_dst_rdy),
  .arb_grant      (arb_grant),
  .arb_locked     (arb_locked),
  .arb_take       (arb_take),
  .arb_last       (arb_last)
);

// File: tb/tb_cbsw_top.sv
module tb_cbsw_top;

  localparam int NP = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [DW-1:0]    up_in_data = '0;
  logic             up_in_sop = 1'b0, up_in_eop = 1'b0, up_in_src_rdy = 1'b0;
  logic             up_in_dst_rdy;
  logic [NP*DW-1:0] dn_out_data;
  logic [NP-1:0]    dn_out_sop, dn_out_eop, dn_out_src_rdy;
  logic [NP-1:0]    dn_out_dst_rdy = '1;
  logic [NP*DW-1:0] dn_in_data;
  logic [NP-1:0]    dn_in_sop, dn_in_eop, dn_in_src_rdy, dn_in_dst_rdy;
  logic [DW-1:0]    up_out_data;
  logic             up_out_sop, up_out_eop, up_out_src_rdy;
  logic             up_out_dst_rdy = 1'b1;

  logic [DW-1:0] di_d [NP];
  logic          di_s [NP];
  logic          di_e [NP];
  logic          di_v [NP];

  initial for (int p = 0; p < NP; p++) begin
    di_d[p] = '0; di_s[p] = 1'b0; di_e[p] = 1'b0; di_v[p] = 1'b0;
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      dn_in_data[p*DW +: DW] = di_d[p];
      dn_in_sop[p]           = di_s[p];
      dn_in_eop[p]           = di_e[p];
      dn_in_src_rdy[p]       = di_v[p];
    end
  end

  cbsw_top #(.N_DOWN(NP), .DW(DW)) dut (.*);

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Backpressure generators
  bit dn_bp = 0, up_bp = 0;
  always @(posedge clk) begin
    #1;
    for (int p = 0; p < NP; p++) dn_out_dst_rdy[p] = dn_bp ? ($urandom % 4 != 0) : 1'b1;
    up_out_dst_rdy = up_bp ? ($urandom % 3 != 0) : 1'b1;
  end

  // Scoreboard queues: {sop, eop, data}
  logic [17:0] exp_dn [NP][$];
  logic [17:0] exp_up [NP][$];
  int sop_order[$];

  int bc_cnt = 0, bc_first = 0, bc_last = 0;
  int atom_bad = 0, leak = 0, il_bad = 0, pkts_up = 0, up_stall = 0;
  bit up_only = 0, in_pkt = 0;
  int cur_src = 0;

  // Monitors sample between edges
  always @(negedge clk) if (rst_n) begin
    logic [NP-1:0] f;
    f = dn_out_src_rdy & dn_out_dst_rdy;
    if (f != '0 && f != '1) atom_bad++;
    if (up_only && dn_out_src_rdy != '0) leak++;
    for (int p = 0; p < NP; p++) begin
      if (f[p]) begin
        logic [17:0] got, e;
        got = {dn_out_sop[p], dn_out_eop[p], dn_out_data[p*DW +: DW]};
        if (exp_dn[p].size() == 0) chk(0, "R2 unexpected copy", int'(got), -1);
        else begin
          e = exp_dn[p].pop_front();
          chk(got == e, "R2 copied word", int'(got), int'(e));
        end
        if (p == 0) begin
          if (bc_cnt == 0) bc_first = cyc;
          bc_last = cyc;
          bc_cnt++;
        end
      end
    end
    if (up_out_src_rdy && up_out_dst_rdy) begin
      logic [17:0] got, e;
      got = {up_out_sop, up_out_eop, up_out_data};
      if (up_out_sop) begin
        if (in_pkt) il_bad++;
        cur_src = int'(up_out_data[3:0]);
        sop_order.push_back(cur_src);
        pkts_up++;
        in_pkt = 1;
      end
      if (cur_src >= NP) chk(0, "R10 source id", cur_src, NP - 1);
      else if (exp_up[cur_src].size() == 0) chk(0, "R5 unexpected word", int'(got), -1);
      else begin
        e = exp_up[cur_src].pop_front();
        chk(got == e, "R5 R10 merged word", int'(got), int'(e));
      end
      if (up_out_eop) in_pkt = 0;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    in_pkt = 0;
    sop_order.delete();
  endtask

  task automatic send_up(input int len, input int tag);
    bit r;
    @(posedge clk); #1;
    for (int w = 0; w < len; w++) begin
      logic [15:0] d;
      d = {tag[7:0], w[7:0]};
      for (int p = 0; p < NP; p++) exp_dn[p].push_back({w == 0, w == len - 1, d});
      up_in_data = d; up_in_sop = (w == 0); up_in_eop = (w == len - 1); up_in_src_rdy = 1'b1;
      forever begin
        @(negedge clk); r = up_in_dst_rdy;
        if (!r) up_stall++;
        @(posedge clk); #1;
        if (r) break;
      end
    end
    up_in_src_rdy = 1'b0;
  endtask

  task automatic send_dn(input int p, input int len, input int tag);
    bit r;
    @(posedge clk); #1;
    for (int w = 0; w < len; w++) begin
      logic [15:0] d;
      d = (w == 0) ? {tag[11:0], 4'(p)} : {4'(p), tag[7:0], 4'(w)};
      exp_up[p].push_back({w == 0, w == len - 1, d});
      di_d[p] = d; di_s[p] = (w == 0); di_e[p] = (w == len - 1); di_v[p] = 1'b1;
      forever begin
        @(negedge clk); r = dn_in_dst_rdy[p];
        @(posedge clk); #1;
        if (r) break;
      end
    end
    di_v[p] = 1'b0;
  endtask

  task automatic run_port(input int p, input int npk);
    for (int k = 0; k < npk; k++) begin
      send_dn(p, 1 + int'($urandom % 5), k * 16 + p);
      if ($urandom % 2 == 1) repeat ($urandom % 3) @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(dn_out_src_rdy == '0, "R1 dn valid", int'(dn_out_src_rdy), 0);
    chk(up_out_src_rdy == 1'b0, "R1 up valid", int'(up_out_src_rdy), 0);
    chk(up_in_dst_rdy == 1'b1, "R1 up ready", int'(up_in_dst_rdy), 1);
    chk(dn_in_dst_rdy == '1, "R1 dn ready", int'(dn_in_dst_rdy), 15);

    // R2 R9: streaming copy with free sinks
    bc_cnt = 0; up_stall = 0;
    send_up(8, 1);
    repeat (10) @(posedge clk);
    chk(bc_cnt == 8, "R9 copied words", bc_cnt, 8);
    chk(bc_last - bc_first == 7, "R9 consecutive", bc_last - bc_first, 7);
    chk(up_stall == 0, "R9 input stalls", up_stall, 0);

    // R3 R4: copy under independent per-port backpressure
    dn_bp = 1;
    for (int k = 1; k <= 6; k++) begin
      send_up(k, 16 + k);
      repeat (k % 3) @(posedge clk);
    end
    repeat (80) @(posedge clk);
    dn_bp = 0;
    repeat (5) @(posedge clk);
    chk(atom_bad == 0, "R3 all-or-none", atom_bad, 0);
    for (int p = 0; p < NP; p++)
      chk(exp_dn[p].size() == 0, "R4 copy drained", exp_dn[p].size(), 0);

    // R6: all ports request at once after reset
    do_reset();
    up_only = 1;
    fork
      send_dn(0, 3, 100);
      send_dn(1, 3, 101);
      send_dn(2, 3, 102);
      send_dn(3, 3, 103);
    join
    repeat (20) @(posedge clk);
    chk(sop_order.size() == 4, "R6 packet count", sop_order.size(), 4);
    for (int i = 0; i < 4; i++)
      if (i < sop_order.size()) chk(sop_order[i] == i, "R6 rr order", sop_order[i], i);

    // R7: single-word packet does not lock
    do_reset();
    fork
      begin send_dn(0, 1, 200); send_dn(0, 1, 201); end
      send_dn(1, 2, 202);
    join
    repeat (20) @(posedge clk);
    chk(sop_order.size() == 3, "R7 packet count", sop_order.size(), 3);
    if (sop_order.size() == 3) begin
      chk(sop_order[0] == 0, "R7 order 0", sop_order[0], 0);
      chk(sop_order[1] == 1, "R7 order 1", sop_order[1], 1);
      chk(sop_order[2] == 0, "R7 order 2", sop_order[2], 0);
    end

    // R5 R4 R10: mixed contention with random upstream stalls
    pkts_up = 0; il_bad = 0;
    up_bp = 1;
    fork
      run_port(0, 6);
      run_port(1, 6);
      run_port(2, 6);
      run_port(3, 6);
    join
    repeat (200) @(posedge clk);
    up_bp = 0;
    repeat (10) @(posedge clk);
    chk(pkts_up == 24, "R5 packets merged", pkts_up, 24);
    chk(il_bad == 0, "R5 no interleave", il_bad, 0);
    for (int p = 0; p < NP; p++)
      chk(exp_up[p].size() == 0, "R4 merge drained", exp_up[p].size(), 0);
    chk(leak == 0, "R8 no lateral path", leak, 0);
    up_only = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule